// File: doc/BRIEF.md
# Uncorrectable Error Status, Mask and Reporting Unit

This block sits in a link endpoint and collects one-cycle detection pulses for eight uncorrectable error types. Each pulse is recorded in a status register whatever the mask or enable settings are. The unit then applies the per-error mask and severity. For the first unmasked error it captures the header of the offending packet. It also chooses whether to ask for an error message, and at which level: correctable, non-fatal or fatal.

Software uses a small word-wide register port. The status, mask, severity and control registers can be written. The status register is write-one-to-clear. The header log and its state can only be read. Message requests leave on a valid/ready output and are held until accepted. Building the message packet is left to a neighbouring block.

A non-fatal error that the receiver can tolerate is flagged as advisory by the detecting logic. When the advanced reporting capability is on, the unit downgrades it to a correctable message. When that capability is off, no message is sent for it.

Top module: `err_report_unit`

## Requirements
- R1: Error bit positions in `err_pulse`, and in the status, mask, severity and advisory vectors, are: 0 poisoned packet, 1 completion timeout, 2 completer abort, 3 unexpected completion, 4 unsupported request, 5 malformed packet, 6 end-to-end CRC failure, 7 flow-control protocol error. A pulse sets its status bit on the next edge, whatever the mask and control bits are.
- R2: Writing address 0 clears every status bit whose write-data bit is 1. If an error pulse hits the same bit in the same cycle, the bit stays set.
- R3: An error whose mask bit (address 1) is 1 is neither captured in the header log nor the cause of any message.
- R4: An unmasked error with severity bit 1 (address 2) requests a fatal message (`msg_type` 3) if control bit 2 is 1. An unmasked non-advisory error with severity bit 0 requests a non-fatal message (`msg_type` 2) if control bit 1 is 1.
- R5: An unmasked error with severity 0 and its `err_adv` bit set requests a correctable message (`msg_type` 1) when control bit 4 (advanced capability) and control bit 0 (correctable enable) are both 1, and never a non-fatal one.
- R6: With control bit 4 at 0, an advisory non-fatal error causes no message.
- R7: Messages for the poisoned-packet error (bit 0) are sent only while control bit 3 (parity-error response) is 1. Its status bit and header capture are not affected by that bit.
- R8: The header log captures `err_hdr` for the first unmasked error, taking the lowest bit index on a tie. Address 4 reads log-valid in bit 0 and the captured error index in bits 6:4. Addresses 5 to 8 read header words 0 to 3. The log stays frozen until the captured error's status bit is cleared. A new error in that same cycle is captured at once.
- R9: Errors arriving together produce one request, at the highest class among them (fatal over non-fatal over correctable). A request that arrives while the output is busy merges with any waiting request, keeping the higher class.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and `msg_type` hold. `msg_type` is 0 whenever `msg_valid` is 0.
- R11: After reset every register reads 0, and no message is requested. Address 3 holds the control bits 4:0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| err_pulse | input | 8 | One-cycle error detection pulses |
| err_adv | input | 8 | Marks a pulse as tolerable (advisory if non-fatal) |
| err_hdr | input | 128 | Header of the packet tied to this cycle's pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_type | output | 2 | 1 correctable, 2 non-fatal, 3 fatal |

## Verification
Directed cases separate the outcomes one at a time. A masked pulse with every enable on shows that status is kept apart from reporting. A single unmasked non-fatal pulse, then a fatal and non-fatal pair in one cycle, show class choice and priority. Advisory pulses are sent with the advanced capability off and then on, which shows the downgrade rule. A poisoned packet is sent with parity response off, which isolates that gate. A clear and a set of the same status bit in one cycle, and a second error against a frozen log, probe the corner cases. A long constrained-random run then mixes sparse pulses, random register writes and a random `msg_ready`, so that merging under back-pressure is compared against the bench's own model on every cycle.

// File: rtl/err_report_unit.sv
module err_report_unit #(
  parameter int DW = 32,
  parameter int HDR_WORDS = 4,
  parameter int AW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            err_pulse,
  input  logic [7:0]            err_adv,
  input  logic [DW*HDR_WORDS-1:0] err_hdr,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [1:0]            msg_type
);
  localparam int NE = 8;
  localparam int IW = $clog2(NE);
  localparam int HW = DW * HDR_WORDS;
  localparam int CW = 5;
  localparam logic [AW-1:0] A_STS = 0, A_MSK = 1, A_SEV = 2, A_CTL = 3, A_LOG = 4;
  localparam int A_HDR = 5;
  localparam int C_COR = 0, C_NF = 1, C_FAT = 2, C_PERR = 3, C_ADV = 4;

  logic [NE-1:0] sts, msk, sev;
  logic [CW-1:0] ctl;
  logic          log_v;
  logic [IW-1:0] first;
  logic [HW-1:0] hlog;
  logic [1:0]    pend;

  wire [NE-1:0] clr = (reg_we && reg_addr == A_STS) ? reg_wdata[NE-1:0] : '0;
  wire [NE-1:0] unm = err_pulse & ~msk;
  wire [NE-1:0] rep = unm & {{(NE-1){1'b1}}, ctl[C_PERR]};
  wire want_fat = |(rep & sev) & ctl[C_FAT];
  wire want_nf  = |(rep & ~sev & ~err_adv) & ctl[C_NF];
  wire want_cor = |(rep & ~sev & err_adv) & ctl[C_ADV] & ctl[C_COR];
  wire [1:0] new_t = want_fat ? 2'd3 : want_nf ? 2'd2 : want_cor ? 2'd1 : 2'd0;
  wire [1:0] merged = (pend > new_t) ? pend : new_t;
  wire slot_free = !msg_valid || msg_ready;
  wire log_free = !log_v || clr[first];
  wire capture = log_free && (|unm);

  logic [IW-1:0] low_idx;
  always_comb begin
    low_idx = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (unm[i]) low_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0; msk <= '0; sev <= '0; ctl <= '0;
      log_v <= 1'b0; first <= '0; hlog <= '0;
      pend <= '0; msg_valid <= 1'b0; msg_type <= '0;
    end else begin
      sts <= (sts & ~clr) | err_pulse;
      if (reg_we) begin
        case (reg_addr)
          A_MSK: msk <= reg_wdata[NE-1:0];
          A_SEV: sev <= reg_wdata[NE-1:0];
          A_CTL: ctl <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (capture) begin
        log_v <= 1'b1;
        first <= low_idx;
        hlog  <= err_hdr;
      end else if (log_v && clr[first]) begin
        log_v <= 1'b0;
      end
      if (slot_free) begin
        msg_valid <= merged != 2'd0;
        msg_type  <= merged;
        pend      <= '0;
      end else begin
        pend <= merged;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STS: reg_rdata[NE-1:0] = sts;
      A_MSK: reg_rdata[NE-1:0] = msk;
      A_SEV: reg_rdata[NE-1:0] = sev;
      A_CTL: reg_rdata[CW-1:0] = ctl;
      A_LOG: begin
        reg_rdata[0] = log_v;
        reg_rdata[4 +: IW] = first;
      end
      default: ;
    endcase
    for (int w = 0; w < HDR_WORDS; w++)
      if (reg_addr == AW'(A_HDR + w)) reg_rdata = hlog[w*DW +: DW];
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DW-1:NE];

  assert_status_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |=> ((sts & $past(err_pulse)) == $past(err_pulse)));

  assert_masked_no_log_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_v && ((err_pulse & ~msk) == '0)) |=> !log_v);

  assert_log_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_v && !clr[first]) |=> (log_v && $stable(hlog) && $stable(first)));

  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type)));

  assert_type_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid == (msg_type != 2'd0)));
endmodule

// File: tb/sim_err_report_unit.sv
module sim_err_report_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] err_pulse = '0, err_adv = '0;
  logic [127:0] err_hdr = '0;
  logic reg_we = 1'b0, msg_ready = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid;
  logic [1:0] msg_type;

  err_report_unit u0 (.clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_adv(err_adv),
    .err_hdr(err_hdr), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type));

  always #10 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 0;
  logic [7:0] m_sts = 0, m_msk = 0, m_sev = 0;
  logic [4:0] m_ctl = 0;
  logic m_logv = 0, m_mv = 0;
  logic [2:0] m_first = 0;
  logic [127:0] m_hlog = 0;
  logic [1:0] m_pend = 0, m_mt = 0;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return {24'd0, m_sts};
      4'd1: return {24'd0, m_msk};
      4'd2: return {24'd0, m_sev};
      4'd3: return {27'd0, m_ctl};
      4'd4: return {25'd0, m_first, 3'd0, m_logv};
      4'd5, 4'd6, 4'd7, 4'd8: return m_hlog[(a - 4'd5) * 32 +: 32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [1:0] model_class(input logic [7:0] p, input logic [7:0] adv);
    logic [7:0] r;
    r = p & ~m_msk;
    if (!m_ctl[3]) r[0] = 1'b0;
    if (m_ctl[2] && |(r & m_sev)) return 2'd3;
    if (m_ctl[1] && |(r & ~m_sev & ~adv)) return 2'd2;
    if (m_ctl[4] && m_ctl[0] && |(r & ~m_sev & adv)) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic step(input string tg, input logic [7:0] p, input logic [7:0] adv,
                      input logic [127:0] hdr, input logic we, input logic [3:0] a,
                      input logic [31:0] wd, input logic rdy);
    logic [7:0] clr, unm;
    logic [2:0] low;
    logic [1:0] nt, mg;
    @(negedge clk);
    err_pulse = p; err_adv = adv; err_hdr = hdr;
    reg_we = we; reg_addr = a; reg_wdata = wd; msg_ready = rdy;
    #1;
    chk(tg, "msg_valid", {31'd0, msg_valid}, {31'd0, m_mv});
    chk(tg, "msg_type", {30'd0, msg_type}, {30'd0, m_mt});
    chk(tg, "rdata", reg_rdata, model_read(a));
    clr = (we && a == 4'd0) ? wd[7:0] : 8'd0;
    unm = p & ~m_msk;
    low = 0;
    for (int i = 7; i >= 0; i--) if (unm[i]) low = 3'(i);
    nt = model_class(p, adv);
    mg = (m_pend > nt) ? m_pend : nt;
    if ((!m_logv || clr[m_first]) && |unm) begin
      m_logv = 1; m_first = low; m_hlog = hdr;
    end else if (m_logv && clr[m_first]) m_logv = 0;
    m_sts = (m_sts & ~clr) | p;
    if (!m_mv || rdy) begin
      m_mv = (mg != 0); m_mt = mg; m_pend = 0;
    end else m_pend = mg;
    if (we) case (a)
      4'd1: m_msk = wd[7:0];
      4'd2: m_sev = wd[7:0];
      4'd3: m_ctl = wd[4:0];
      default: ;
    endcase
  endtask

  task automatic idle(input string tg, input logic [3:0] a, input logic rdy);
    step(tg, 8'd0, 8'd0, 128'd0, 1'b0, a, 32'd0, rdy);
  endtask

  task automatic wr(input string tg, input logic [3:0] a, input logic [31:0] d);
    step(tg, 8'd0, 8'd0, 128'd0, 1'b1, a, d, 1'b1);
  endtask

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) idle("R11", 4'(a), 1'b0);
    wr("R11", 4'd3, 32'h1f);
    idle("R11", 4'd3, 1'b1);
    wr("R3", 4'd1, 32'h04);
    step("R3", 8'h04, 8'h00, {4{32'hCAFE0002}}, 1'b0, 4'd0, 32'd0, 1'b1);
    idle("R1", 4'd0, 1'b1);
    idle("R3", 4'd4, 1'b1);
    step("R4", 8'h02, 8'h00, {4{32'h11112222}}, 1'b0, 4'd4, 32'd0, 1'b1);
    idle("R4", 4'd5, 1'b1);
    idle("R8", 4'd4, 1'b1);
    wr("R4", 4'd2, 32'h20);
    step("R9", 8'h30, 8'h00, {4{32'h33334444}}, 1'b0, 4'd8, 32'd0, 1'b0);
    step("R10", 8'h08, 8'h08, 128'd0, 1'b0, 4'd0, 32'd0, 1'b0);
    idle("R10", 4'd0, 1'b0);
    idle("R10", 4'd0, 1'b1);
    idle("R9", 4'd0, 1'b1);
    idle("R8", 4'd6, 1'b1);
    wr("R6", 4'd3, 32'h0f);
    step("R6", 8'h40, 8'h40, 128'd0, 1'b0, 4'd0, 32'd0, 1'b1);
    idle("R6", 4'd0, 1'b1);
    wr("R5", 4'd3, 32'h1f);
    step("R5", 8'h40, 8'h40, 128'd0, 1'b0, 4'd0, 32'd0, 1'b1);
    idle("R5", 4'd0, 1'b1);
    wr("R7", 4'd3, 32'h17);
    step("R7", 8'h01, 8'h00, 128'd0, 1'b0, 4'd0, 32'd0, 1'b1);
    idle("R7", 4'd0, 1'b1);
    step("R2", 8'h80, 8'h00, 128'd0, 1'b1, 4'd0, 32'h80, 1'b1);
    idle("R2", 4'd0, 1'b1);
    step("R8", 8'h00, 8'h00, 128'd0, 1'b1, 4'd0, 32'h02, 1'b1);
    idle("R8", 4'd4, 1'b1);
    step("R8", 8'h18, 8'h00, {4{32'h55556666}}, 1'b0, 4'd4, 32'd0, 1'b1);
    idle("R8", 4'd4, 1'b1);
    idle("R8", 4'd7, 1'b1);
    wr("R2", 4'd0, 32'hff);
    idle("R2", 4'd0, 1'b1);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] p;
      logic we;
      logic [3:0] a;
      p = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'd0;
      we = ($urandom % 8 == 0);
      a = we ? 4'($urandom % 4) : 4'($urandom % 16);
      step("R4,R9", p, 8'($urandom), {$urandom, $urandom, $urandom, $urandom},
           we, a, $urandom, 1'($urandom % 3 != 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule